// File: doc/BRIEF.md
# T=0 Command Exchange Sequencer

This block runs one complete command exchange of the character-level smart-card protocol (T=0) on top of a byte transceiver. A host places a command in a buffer, gives its length and pulses `start`. The sequencer then sends the five header bytes and classifies the command by its length and P3 byte: no data, outgoing data or incoming data. It then waits for procedure bytes from the card and obeys them. Data moves either as the whole remaining block or one byte at a time. The sequencer collects the two status bytes, writes them to a response buffer after any incoming data, and reports the response length with a one-cycle `done` pulse.

The command buffer is read through a combinational read port. The address is the sequencer's own pointer, and the byte on `cmd_rd_data` goes straight to the transmit stream. The receive stream carries a status code with every byte. Any nonzero code, for example a timeout or a parity fault flagged by the transceiver, ends the exchange at once and returns that code.

States: `S_IDLE` (waits for start) → `S_HDR` (sends addresses 0..4) → `S_EXT_HI` and `S_EXT_LO` (read a two-byte count, used only for long commands whose P3 is zero) → `S_PROC` (waits for a procedure byte). From `S_PROC`: a NULL byte stays in `S_PROC`. A status-class byte goes to `S_SW2`. INS or complemented INS goes to `S_TX_DATA` or `S_RX_DATA`, or to `S_SW1` when no data remains. Any other byte goes to `S_SW1`. The data states return to `S_PROC` after one byte in single mode, or go to `S_SW1` once the count reaches zero. Then `S_SW1` → `S_SW2` → `S_DONE` → `S_IDLE`. A receive error in any receiving state jumps straight to `S_DONE`.

Top module: `t0_cmd_seq`

## Requirements
- R1: The header goes out as five bytes read from command addresses 0,1,2,3,4 in that order (CLA, INS, P1, P2, P3). While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R2: Classification by `cmd_len`: 4 means no data. 5 means incoming data, with the count in P3 and a P3 of 0 meaning 256. 6 means outgoing data with the count in P3. 7 or more with a nonzero P3 also means outgoing data with the count in P3. Outgoing data starts at address 5.
- R3: When `cmd_len` is 7 or more and P3 is 0, the count is read from address 5 (high byte) and address 6 (low byte), and these two bytes are not transmitted. Length 7 then means incoming data. Length 8 or more means outgoing data taken from address 7 onward.
- R4: The procedure byte 0x60 (NULL) is skipped and leaves the remaining count unchanged. It is tested before the status class, so it is never taken as SW1.
- R5: A procedure byte with upper nibble 6 or 9 (other than 0x60) is SW1. It is written to the response, and exactly one further byte (SW2) is read before `done`.
- R6: A procedure byte equal to INS moves all remaining data bytes in the command's direction, with no procedure byte between them.
- R7: A procedure byte equal to INS XOR 0xFF moves exactly one data byte, decrements the count and returns to waiting for a procedure byte.
- R8: Any other procedure byte ends the procedure phase. The next two received bytes are taken as SW1 and SW2.
- R9: When the remaining count reaches zero, the procedure phase ends and the next two received bytes are SW1 and SW2. INS or complemented INS received with a zero count moves no data.
- R10: Incoming data is written to response addresses 0, 1, 2, … in order, followed by SW1 and SW2. At `done`, `rsp_len` equals the number of bytes written.
- R11: A received byte with a nonzero `rx_status` is not written. `done` follows in the next cycle, with `err_status` equal to that code and `rsp_len` equal to the number of bytes written before it. A clean exchange ends with `err_status` 0.
- R12: After reset the block is idle, with `done`, `tx_valid`, `rx_ready` and `rsp_wr_en` low. `done` lasts one cycle. `cmd_len` is sampled at the accepted start, and `start` is ignored while `busy`.
- R13: `tx_valid` and `rx_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| cmd_rd_addr | output | LEN_W | Command buffer read address |
| cmd_rd_data | input | 8 | Command buffer byte at `cmd_rd_addr` (same cycle) |
| tx_valid | output | 1 | Byte offered to the transceiver |
| tx_ready | input | 1 | Transceiver accepts the offered byte |
| tx_data | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Sequencer takes the received byte |
| rx_data | input | 8 | Received byte |
| rx_status | input | STAT_W | Error code for the received byte, 0 when clean |
| rsp_wr_en | output | 1 | Response buffer write strobe |
| rsp_wr_addr | output | RSP_AW | Response buffer write address |
| rsp_wr_data | output | 8 | Response buffer write byte |
| done | output | 1 | One-cycle end-of-exchange pulse |
| busy | output | 1 | Exchange in progress |
| rsp_len | output | RSP_AW | Response length, valid with `done` |
| err_status | output | STAT_W | Abort code, 0 when clean, valid with `done` |

## Verification
The closest collision is a receive error on a byte that would otherwise finish the exchange. An example is a faulty SW2, where completion and abort compete in the same cycle. The bench builds receive scripts that flag the SW2 byte, and also a mid-block data byte. It judges that the abort wins: the byte is not written, `err_status` carries the code and `rsp_len` counts only the earlier bytes. A second collision is a fresh `start` with a changed length that arrives while an exchange runs. The bench checks that the transmitted and received bytes still follow the originally sampled length.

// File: rtl/t0_seq_pkg.sv
package t0_seq_pkg;

    localparam logic [7:0] NULL_BYTE = 8'h60;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR,
        S_EXT_HI,
        S_EXT_LO,
        S_PROC,
        S_TX_DATA,
        S_RX_DATA,
        S_SW1,
        S_SW2,
        S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        PB_NULL,
        PB_SW1,
        PB_INS,
        PB_INS_N,
        PB_OTHER
    } pb_kind_t;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_OUT,
        DIR_IN
    } xfer_dir_t;

endpackage

// File: rtl/t0_pb_decode.sv
module t0_pb_decode
    import t0_seq_pkg::*;
(
    input  logic [7:0] pb,
    input  logic [7:0] ins,
    output pb_kind_t   kind
);
    // NULL precedes the status class so that 0x60 never counts as SW1.
    always_comb begin
        if (pb == NULL_BYTE) begin
            kind = PB_NULL;
        end else if (pb[7:4] == 4'h6 || pb[7:4] == 4'h9) begin
            kind = PB_SW1;
        end else if (pb == ins) begin
            kind = PB_INS;
        end else if (pb == ~ins) begin
            kind = PB_INS_N;
        end else begin
            kind = PB_OTHER;
        end
    end
endmodule

// File: rtl/t0_cmd_classify.sv
module t0_cmd_classify
    import t0_seq_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int CNT_W = 16
) (
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       p3,
    output xfer_dir_t        dir,
    output logic [CNT_W-1:0] cnt,
    output logic             need_ext
);
    localparam logic [CNT_W-1:0] FULL_SHORT = CNT_W'(256);

    always_comb begin
        dir      = DIR_NONE;
        cnt      = '0;
        need_ext = 1'b0;
        if (cmd_len == LEN_W'(5)) begin
            dir = DIR_IN;
            cnt = (p3 == 8'h00) ? FULL_SHORT : CNT_W'(p3);
        end else if (cmd_len == LEN_W'(6)) begin
            dir = DIR_OUT;
            cnt = CNT_W'(p3);
        end else if (cmd_len == LEN_W'(7)) begin
            if (p3 == 8'h00) begin
                dir      = DIR_IN;
                need_ext = 1'b1;
            end else begin
                dir = DIR_OUT;
                cnt = CNT_W'(p3);
            end
        end else if (cmd_len > LEN_W'(7)) begin
            dir = DIR_OUT;
            if (p3 == 8'h00) begin
                need_ext = 1'b1;
            end else begin
                cnt = CNT_W'(p3);
            end
        end
    end
endmodule

// File: rtl/t0_cmd_seq.sv
module t0_cmd_seq
    import t0_seq_pkg::*;
#(
    parameter int LEN_W  = 9,
    parameter int CNT_W  = 16,
    parameter int RSP_AW = 9,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic [LEN_W-1:0]  cmd_rd_addr,
    input  logic [7:0]        cmd_rd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic [STAT_W-1:0] rx_status,
    output logic              rsp_wr_en,
    output logic [RSP_AW-1:0] rsp_wr_addr,
    output logic [7:0]        rsp_wr_data,
    output logic              done,
    output logic              busy,
    output logic [RSP_AW-1:0] rsp_len,
    output logic [STAT_W-1:0] err_status
);
    localparam logic [LEN_W-1:0] IDX_INS = LEN_W'(1);
    localparam logic [LEN_W-1:0] IDX_P3  = LEN_W'(4);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    seq_state_t        state;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  ptr;
    logic [7:0]        ins_q;
    logic [7:0]        ext_hi_q;
    logic [CNT_W-1:0]  cnt;
    xfer_dir_t         dir_q;
    logic              blk_q;
    logic [RSP_AW-1:0] ridx;
    logic [RSP_AW-1:0] rsp_len_q;
    logic [STAT_W-1:0] err_q;

    pb_kind_t          kind;
    xfer_dir_t         cls_dir;
    logic [CNT_W-1:0]  cls_cnt;
    logic              cls_ext;
    logic              tx_fire;
    logic              rx_fire;
    logic              rx_bad;

    t0_pb_decode u_pb_decode (
        .pb   (rx_data),
        .ins  (ins_q),
        .kind (kind)
    );

    t0_cmd_classify #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_classify (
        .cmd_len  (len_q),
        .p3       (cmd_rd_data),
        .dir      (cls_dir),
        .cnt      (cls_cnt),
        .need_ext (cls_ext)
    );

    assign tx_fire = tx_valid && tx_ready;
    assign rx_fire = rx_valid && rx_ready;
    assign rx_bad  = rx_fire && (rx_status != '0);

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            len_q     <= '0;
            ptr       <= '0;
            ins_q     <= '0;
            ext_hi_q  <= '0;
            cnt       <= '0;
            dir_q     <= DIR_NONE;
            blk_q     <= 1'b0;
            ridx      <= '0;
            rsp_len_q <= '0;
            err_q     <= '0;
        end else if (rx_bad) begin
            err_q     <= rx_status;
            rsp_len_q <= ridx;
            state     <= S_DONE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        len_q <= cmd_len;
                        ptr   <= '0;
                        ridx  <= '0;
                        err_q <= '0;
                        state <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (tx_fire) begin
                        ptr <= ptr + 1'b1;
                        if (ptr == IDX_INS) begin
                            ins_q <= cmd_rd_data;
                        end
                        if (ptr == IDX_P3) begin
                            dir_q <= cls_dir;
                            cnt   <= cls_cnt;
                            state <= cls_ext ? S_EXT_HI : S_PROC;
                        end
                    end
                end
                S_EXT_HI: begin
                    ext_hi_q <= cmd_rd_data;
                    ptr      <= ptr + 1'b1;
                    state    <= S_EXT_LO;
                end
                S_EXT_LO: begin
                    cnt   <= CNT_W'({ext_hi_q, cmd_rd_data});
                    ptr   <= ptr + 1'b1;
                    state <= S_PROC;
                end
                S_PROC: begin
                    if (rx_fire) begin
                        unique case (kind)
                            PB_NULL: state <= S_PROC;
                            PB_SW1: begin
                                ridx  <= ridx + 1'b1;
                                state <= S_SW2;
                            end
                            PB_INS, PB_INS_N: begin
                                blk_q <= (kind == PB_INS);
                                if (cnt == '0) begin
                                    state <= S_SW1;
                                end else if (dir_q == DIR_IN) begin
                                    state <= S_RX_DATA;
                                end else begin
                                    state <= S_TX_DATA;
                                end
                            end
                            default: state <= S_SW1;
                        endcase
                    end
                end
                S_TX_DATA: begin
                    if (tx_fire) begin
                        ptr <= ptr + 1'b1;
                        cnt <= cnt - 1'b1;
                        if (cnt == ONE) begin
                            state <= S_SW1;
                        end else if (!blk_q) begin
                            state <= S_PROC;
                        end
                    end
                end
                S_RX_DATA: begin
                    if (rx_fire) begin
                        ridx <= ridx + 1'b1;
                        cnt  <= cnt - 1'b1;
                        if (cnt == ONE) begin
                            state <= S_SW1;
                        end else if (!blk_q) begin
                            state <= S_PROC;
                        end
                    end
                end
                S_SW1: begin
                    if (rx_fire) begin
                        ridx  <= ridx + 1'b1;
                        state <= S_SW2;
                    end
                end
                S_SW2: begin
                    if (rx_fire) begin
                        ridx      <= ridx + 1'b1;
                        rsp_len_q <= ridx + 1'b1;
                        state     <= S_DONE;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_valid    = 1'b0;
        rx_ready    = 1'b0;
        rsp_wr_en   = 1'b0;
        cmd_rd_addr = ptr;
        tx_data     = cmd_rd_data;
        rsp_wr_addr = ridx;
        rsp_wr_data = rx_data;
        done        = (state == S_DONE);
        busy        = (state != S_IDLE);
        rsp_len     = rsp_len_q;
        err_status  = err_q;
        unique case (state)
            S_HDR, S_TX_DATA: tx_valid = 1'b1;
            S_PROC: begin
                rx_ready  = 1'b1;
                rsp_wr_en = rx_valid && (rx_status == '0) && (kind == PB_SW1);
            end
            S_RX_DATA, S_SW1, S_SW2: begin
                rx_ready  = 1'b1;
                rsp_wr_en = rx_valid && (rx_status == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/t0_cmd_seq_chk.sv
module t0_cmd_seq_chk #(
    parameter int RSP_AW = 9,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [STAT_W-1:0] rx_status,
    input logic              rsp_wr_en,
    input logic              done,
    input logic              busy,
    input logic [RSP_AW-1:0] rsp_len,
    input logic [STAT_W-1:0] err_status
);
    p_tx_rx_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_status != '0 |=> done && err_status == $past(rx_status));

    p_abort_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_status != '0 |-> !rsp_wr_en);

    p_wr_from_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> rx_valid && rx_ready);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stay_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    p_sw_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_status == '0 |-> rsp_len >= RSP_AW'(2));
endmodule

bind t0_cmd_seq t0_cmd_seq_chk #(
    .RSP_AW (RSP_AW),
    .STAT_W (STAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_status  (rx_status),
    .rsp_wr_en  (rsp_wr_en),
    .done       (done),
    .busy       (busy),
    .rsp_len    (rsp_len),
    .err_status (err_status)
);

// File: tb/t0_cmd_seq_tb.sv
`timescale 1ns/1ps
module t0_cmd_seq_tb;
    localparam int LW = 9;
    localparam int CW = 16;
    localparam int AW = 9;
    localparam int SW = 4;
    localparam logic [7:0] INS = 8'hB2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          start = 1'b0;
    logic [LW-1:0] cmd_len = '0;
    logic [LW-1:0] cmd_rd_addr;
    logic [7:0]    cmd_rd_data;
    logic          tx_valid, tx_ready, rx_valid, rx_ready;
    logic [7:0]    tx_data, rx_data, rsp_wr_data;
    logic [SW-1:0] rx_status, err_status;
    logic          rsp_wr_en, done, busy;
    logic [AW-1:0] rsp_wr_addr, rsp_len;

    logic [7:0]    cmd_mem [0:511];
    logic [7:0]    rxq [0:299];
    logic [SW-1:0] rxs [0:299];
    int rxn = 0, rxp = 0;
    logic [7:0] exp_tx [0:299];
    logic [7:0] exp_rsp [0:299];
    logic [7:0] got_tx [0:299];
    logic [7:0] got_rsp [0:511];
    int exp_txn, exp_rspn, got_txn, got_wr;
    logic [SW-1:0] exp_err;
    int len_v;
    bit stall_en = 0, poke = 0, took = 0;
    int cyc = 0, excl_bad = 0;
    int checks = 0, errors = 0;

    assign cmd_rd_data = cmd_mem[cmd_rd_addr];
    assign rx_valid  = (rxp < rxn);
    assign rx_data   = rx_valid ? rxq[rxp] : 8'h00;
    assign rx_status = rx_valid ? rxs[rxp] : '0;

    t0_cmd_seq #(.LEN_W(LW), .CNT_W(CW), .RSP_AW(AW), .STAT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_status(rx_status), .rsp_wr_en(rsp_wr_en), .rsp_wr_addr(rsp_wr_addr),
        .rsp_wr_data(rsp_wr_data), .done(done), .busy(busy),
        .rsp_len(rsp_len), .err_status(err_status)
    );

    // Input driver: changes one time unit after each rising edge
    initial tx_ready = 1'b1;
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (took) begin
            rxp = rxp + 1;
            took = 0;
        end
        tx_ready = !(stall_en && cyc[0]);
    end

    // Monitor: samples at the falling edge
    always @(negedge clk) begin
        if (tx_valid && tx_ready) begin
            got_tx[got_txn] = tx_data;
            got_txn = got_txn + 1;
        end
        if (rx_valid && rx_ready) took = 1;
        if (rsp_wr_en) begin
            got_rsp[rsp_wr_addr] = rsp_wr_data;
            got_wr = got_wr + 1;
        end
        if (tx_valid && rx_ready) excl_bad = excl_bad + 1;
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic setup(input int len, input logic [7:0] p3);
        len_v = len;
        rxn = 0; rxp = 0; took = 0;
        got_txn = 0; got_wr = 0; exp_rspn = 0; exp_err = '0;
        cmd_mem[0] = 8'hA0; cmd_mem[1] = INS; cmd_mem[2] = 8'h11;
        cmd_mem[3] = 8'h22; cmd_mem[4] = p3;
        for (int i = 0; i < 5; i++) exp_tx[i] = cmd_mem[i];
        exp_txn = 5;
    endtask

    task automatic push(input logic [7:0] b, input logic [SW-1:0] st);
        rxq[rxn] = b; rxs[rxn] = st; rxn = rxn + 1;
    endtask

    task automatic want_rsp(input logic [7:0] b);
        exp_rsp[exp_rspn] = b; exp_rspn = exp_rspn + 1;
    endtask

    task automatic want_tx(input logic [7:0] b);
        exp_tx[exp_txn] = b; exp_txn = exp_txn + 1;
    endtask

    task automatic run(input string req);
        int w, bad_i;
        @(posedge clk); #1 start = 1'b1; cmd_len = LW'(len_v);
        @(posedge clk); #1 start = 1'b0;
        if (poke) begin
            @(posedge clk); #1 start = 1'b1; cmd_len = LW'(6);
            @(posedge clk); #1 start = 1'b0;
        end
        w = 0;
        do begin
            @(negedge clk);
            w = w + 1;
        end while (!done && w < 3000);
        chk(done, {req, " done reached"}, int'(done), 1);
        chk(got_txn == exp_txn, {req, " tx count"}, got_txn, exp_txn);
        bad_i = -1;
        for (int i = 0; i < exp_txn && i < got_txn; i++)
            if (bad_i < 0 && got_tx[i] != exp_tx[i]) bad_i = i;
        chk(bad_i < 0, {req, " tx byte"}, (bad_i < 0) ? 0 : int'(got_tx[bad_i]),
            (bad_i < 0) ? 0 : int'(exp_tx[bad_i]));
        chk(got_wr == exp_rspn, {req, " rsp writes"}, got_wr, exp_rspn);
        chk(int'(rsp_len) == exp_rspn, {req, " rsp_len"}, int'(rsp_len), exp_rspn);
        bad_i = -1;
        for (int i = 0; i < exp_rspn; i++)
            if (bad_i < 0 && got_rsp[i] !== exp_rsp[i]) bad_i = i;
        chk(bad_i < 0, {req, " rsp byte"}, (bad_i < 0) ? 0 : int'(got_rsp[bad_i]),
            (bad_i < 0) ? 0 : int'(exp_rsp[bad_i]));
        chk(err_status == exp_err, {req, " err_status"}, int'(err_status), int'(exp_err));
        @(negedge clk);
        chk(!done, {req, " done one cycle"}, int'(done), 0);
        for (int i = 0; i < 512; i++) got_rsp[i] = 8'hxx;
    endtask

    task automatic finish_run();
        chk(excl_bad == 0, "R13 tx/rx exclusive", excl_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 512; i++) begin cmd_mem[i] = 8'h00; got_rsp[i] = 8'hxx; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!done && !tx_valid && !rx_ready && !rsp_wr_en && !busy, "R12 reset idle",
            int'({done, tx_valid, rx_ready, rsp_wr_en, busy}), 0);

        // R4 R5 R8 R9: every procedure byte on a no-data command (length 4)
        for (int b = 0; b < 256; b++) begin
            setup(4, 8'h00);
            push(8'(b), '0); push(8'h34, '0); push(8'h91, '0); push(8'h23, '0);
            if (b == 8'h60) begin
                want_rsp(8'h91); want_rsp(8'h23);              // R4 NULL skipped
            end else if (b[7:4] == 4'h6 || b[7:4] == 4'h9) begin
                want_rsp(8'(b)); want_rsp(8'h34);              // R5 SW1 then SW2
            end else begin
                want_rsp(8'h34); want_rsp(8'h91);              // R8 / R9
            end
            run("R4/R5/R8/R9 proc sweep");
        end

        // R1 R2 R6 R10: incoming block, counts 1..6 and P3=0 meaning 256
        for (int n = 0; n < 7; n++) begin
            int cnt_n;
            cnt_n = (n == 0) ? 256 : n;
            setup(5, 8'(n));
            if (n[0]) push(8'h60, '0);
            push(INS, '0);
            for (int k = 0; k < cnt_n; k++) begin
                push(8'((n * 7 + k * 13) & 255), '0);
                want_rsp(8'((n * 7 + k * 13) & 255));
            end
            push(8'h90, '0); push(8'h00, '0);
            want_rsp(8'h90); want_rsp(8'h00);
            run("R1/R2/R6/R10 incoming block");
        end

        // R2 R4 R7: outgoing one byte at a time with NULLs, stalled transmit on odd n
        for (int n = 1; n < 7; n++) begin
            setup(6, 8'(n));
            stall_en = n[0];
            for (int k = 0; k < n; k++) begin
                cmd_mem[5 + k] = 8'(8'h30 + k);
                want_tx(8'(8'h30 + k));
                push(8'h60, '0); push(~INS, '0);
            end
            push(8'h90, '0); push(8'h00, '0);
            want_rsp(8'h90); want_rsp(8'h00);
            run("R1/R2/R4/R7 outgoing single");
            stall_en = 0;
        end

        // R6 R7: one single byte, then block for the remainder (length 9, P3=4)
        setup(9, 8'h04);
        for (int k = 0; k < 4; k++) begin cmd_mem[5 + k] = 8'(8'hC0 + k); want_tx(8'(8'hC0 + k)); end
        push(~INS, '0); push(INS, '0); push(8'h61, '0); push(8'h10, '0);
        want_rsp(8'h61); want_rsp(8'h10);
        run("R2/R6/R7 mixed outgoing");

        // R8: unknown byte mid-transfer ends the procedure phase
        setup(6, 8'h04);
        for (int k = 0; k < 4; k++) cmd_mem[5 + k] = 8'(8'h50 + k);
        want_tx(8'h50);
        push(~INS, '0); push(8'h55, '0); push(8'h6C, '0); push(8'h10, '0);
        want_rsp(8'h6C); want_rsp(8'h10);
        run("R8 other byte ends loop");

        // R3: extended incoming (length 7, P3=0, count from bytes 5,6)
        setup(7, 8'h00);
        cmd_mem[5] = 8'h00; cmd_mem[6] = 8'h03;
        push(INS, '0);
        for (int k = 0; k < 3; k++) begin push(8'(8'hE0 + k), '0); want_rsp(8'(8'hE0 + k)); end
        push(8'h90, '0); push(8'h00, '0); want_rsp(8'h90); want_rsp(8'h00);
        run("R3 extended incoming");

        // R3: extended outgoing (length 10, P3=0, data from address 7)
        setup(10, 8'h00);
        cmd_mem[5] = 8'h00; cmd_mem[6] = 8'h03;
        for (int k = 0; k < 3; k++) begin cmd_mem[7 + k] = 8'(8'hD0 + k); want_tx(8'(8'hD0 + k)); end
        push(INS, '0); push(8'h90, '0); push(8'h00, '0);
        want_rsp(8'h90); want_rsp(8'h00);
        run("R3 extended outgoing");

        // R11: error on a mid-block data byte
        setup(5, 8'h04);
        push(INS, '0); push(8'hAA, '0); push(8'hBB, 4'd3); push(8'hCC, '0);
        want_rsp(8'hAA); exp_err = 4'd3;
        run("R11 abort on data");

        // R11: error on SW2 collides with completion
        setup(4, 8'h00);
        push(8'h90, '0); push(8'h00, 4'd5);
        want_rsp(8'h90); exp_err = 4'd5;
        run("R11 abort on SW2");

        // R11: error on the first procedure byte
        setup(6, 8'h02);
        push(INS, 4'd9);
        exp_err = 4'd9;
        run("R11 abort on procedure byte");

        // R12: start with another length while busy is ignored
        setup(5, 8'h03);
        poke = 1;
        push(INS, '0);
        for (int k = 0; k < 3; k++) begin push(8'(8'h70 + k), '0); want_rsp(8'(8'h70 + k)); end
        push(8'h90, '0); push(8'h00, '0); want_rsp(8'h90); want_rsp(8'h00);
        run("R12 start ignored while busy");
        poke = 0;

        finish_run();
    end
endmodule